// File: doc/BRIEF.md
# Buzzer Tone Sequencer for a Clock with Alarm, Chime and Countdown

This block turns a fast system clock into a single buzzer drive signal for a 24-hour digital clock. It divides the clock into a high-pitch square wave and a second square wave at half that pitch. It then decides, from the current time, the stored alarm time and the countdown state, whether the buzzer should sound and which of the two pitches to use.

Three sources can ask for sound:
- **Alarm.** Sounds while the current hour and minute equal the alarm hour and minute. This lasts one full minute. The alarm can be muted through an active-low enable pin.
- **Hourly chime.** Sounds during the last ten seconds of minute 59.
- **Countdown warning.** Sounds during the last ten seconds of a running countdown.

The sources are prioritised in the order alarm, chime, countdown. The winning source picks the pitch from the parity of a seconds value, so the tone alternates every second. With no source active, the buzzer rests high, which is silent.

All time inputs are packed BCD bytes (tens digit in bits 7:4, units digit in bits 3:0). The time-keeping and countdown registers live outside this block. All pins are plain control and status signals; no streaming handshake is involved.

Top module: `chime_buzzer`

## Requirements
- R1: The high tone is a square wave whose level holds for HALF = CLK_HZ/(2*TONE_HZ) clock cycles between toggles.
- R2: The low tone toggles on every rising edge of the high tone, so each of its levels lasts 2*HALF cycles.
- R3: The chime source is active when the current minute byte is 0x59 and the current seconds byte lies in 0x50..0x59. At 0x49, or in any other minute, it is inactive.
- R4: The alarm source is active whenever the current hour and minute bytes equal the alarm hour and minute bytes, for every seconds value of that minute.
- R5: When alarm_en_n is 1 the alarm source is never active. The chime and countdown are unaffected by alarm_en_n.
- R6: The countdown source is active only while tmr_run is 1 and the remaining time is 00:00:01 through 00:00:10 (hour byte 0x00, minute byte 0x00, seconds byte 0x01..0x10). At 00:00:00, at 00:00:11 or above, or with tmr_run at 0, it is inactive.
- R7: With no source active, buzzer holds at 1.
- R8: Pitch rule: when bit 0 of the deciding seconds byte is 0 the buzzer follows the high tone, and when it is 1 it follows the low tone. The deciding byte is the current seconds for the alarm and the chime, and the countdown seconds for the countdown. The buzzer is registered, one cycle behind the tones.
- R9: When several sources are active at once, the alarm wins over the chime, and the chime wins over the countdown. This is visible as the seconds byte that sets the pitch.
- R10: While rst_n is 0 the buzzer is 1, and both tones restart low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_hh | input | 8 | Current hour, BCD |
| cur_mm | input | 8 | Current minute, BCD |
| cur_ss | input | 8 | Current second, BCD |
| al_hh | input | 8 | Alarm hour, BCD |
| al_mm | input | 8 | Alarm minute, BCD |
| alarm_en_n | input | 1 | 0 enables alarm sound, 1 mutes it |
| tmr_hh | input | 8 | Countdown remaining hours, BCD |
| tmr_mm | input | 8 | Countdown remaining minutes, BCD |
| tmr_ss | input | 8 | Countdown remaining seconds, BCD |
| tmr_run | input | 1 | Countdown is running |
| buzzer | output | 1 | Buzzer drive, 1 = silent |

## Verification
On every cycle, the assertions check the following:
- the low tone moves only on a rising edge of the high tone;
- a muted alarm or a stopped countdown never wins the source selection;
- the registered buzzer equals 1, the high tone or the low tone exactly as the previous cycle's selection and parity required.

The exact divider period and the BCD window edges can only be shown by the bench's scenarios. The same holds for the choice of seconds byte under competing sources. The bench measures these as the spacing between buzzer transitions.

// File: rtl/chime_pkg.sv
package chime_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ALARM = 2'd1,
    SRC_CHIME = 2'd2,
    SRC_TIMER = 2'd3
  } buzz_src_e;

  function automatic logic bcd_in_range(input logic [7:0] v,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/chime_tone_gen.sv
module chime_tone_gen #(
  parameter int HALF_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tone_hi,
  output logic tone_lo
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tone_hi <= 1'b0;
      tone_lo <= 1'b0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      tone_hi <= ~tone_hi;
      if (!tone_hi) tone_lo <= ~tone_lo;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: low tone only moves together with a rising edge of the high tone
  p_lo_on_hi_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tone_lo) |-> $rose(tone_hi));
endmodule

// File: rtl/chime_trigger.sv
module chime_trigger
  import chime_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cur_hh,
  input  logic [7:0]  cur_mm,
  input  logic [7:0]  cur_ss,
  input  logic [7:0]  al_hh,
  input  logic [7:0]  al_mm,
  input  logic        alarm_en_n,
  input  logic [7:0]  tmr_hh,
  input  logic [7:0]  tmr_mm,
  input  logic [7:0]  tmr_ss,
  input  logic        tmr_run,
  output buzz_src_e   src,
  output logic        odd_sec
);
  logic alarm_hit, chime_hit, timer_hit;

  always_comb begin
    alarm_hit = !alarm_en_n && (cur_hh == al_hh) && (cur_mm == al_mm);
    chime_hit = (cur_mm == 8'h59) && bcd_in_range(cur_ss, 8'h50, 8'h59);
    timer_hit = tmr_run && (tmr_hh == 8'h00) && (tmr_mm == 8'h00) &&
                bcd_in_range(tmr_ss, 8'h01, 8'h10);
  end

  always_comb begin
    src     = SRC_NONE;
    odd_sec = 1'b0;
    if (alarm_hit) begin
      src     = SRC_ALARM;
      odd_sec = cur_ss[0];
    end else if (chime_hit) begin
      src     = SRC_CHIME;
      odd_sec = cur_ss[0];
    end else if (timer_hit) begin
      src     = SRC_TIMER;
      odd_sec = tmr_ss[0];
    end
  end

  // R5: a muted alarm never wins selection
  p_mute_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_en_n |-> (src != SRC_ALARM));
  // R6: a stopped countdown never wins selection
  p_timer_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_run |-> (src != SRC_TIMER));
endmodule

// File: rtl/chime_buzzer.sv
module chime_buzzer
  import chime_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TONE_HZ = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cur_hh,
  input  logic [7:0] cur_mm,
  input  logic [7:0] cur_ss,
  input  logic [7:0] al_hh,
  input  logic [7:0] al_mm,
  input  logic       alarm_en_n,
  input  logic [7:0] tmr_hh,
  input  logic [7:0] tmr_mm,
  input  logic [7:0] tmr_ss,
  input  logic       tmr_run,
  output logic       buzzer
);
  localparam int HALF = CLK_HZ / (2 * TONE_HZ);

  logic      tone_hi, tone_lo, odd_sec;
  buzz_src_e src;

  chime_tone_gen #(.HALF_CYC(HALF)) u_tone (
    .clk     (clk),
    .rst_n   (rst_n),
    .tone_hi (tone_hi),
    .tone_lo (tone_lo)
  );

  chime_trigger u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_hh     (cur_hh),
    .cur_mm     (cur_mm),
    .cur_ss     (cur_ss),
    .al_hh      (al_hh),
    .al_mm      (al_mm),
    .alarm_en_n (alarm_en_n),
    .tmr_hh     (tmr_hh),
    .tmr_mm     (tmr_mm),
    .tmr_ss     (tmr_ss),
    .tmr_run    (tmr_run),
    .src        (src),
    .odd_sec    (odd_sec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                buzzer <= 1'b1;
    else if (src == SRC_NONE)  buzzer <= 1'b1;
    else                       buzzer <= odd_sec ? tone_lo : tone_hi;
  end

  // R7: nothing selected means a silent (high) buzzer next cycle
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NONE) |=> buzzer);
  // R8: even seconds follow the high tone
  p_even_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_NONE && !odd_sec) |=> (buzzer == $past(tone_hi)));
  // R8: odd seconds follow the low tone
  p_odd_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_NONE && odd_sec) |=> (buzzer == $past(tone_lo)));
endmodule

// File: tb/chime_buzzer_test.sv
module chime_buzzer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cur_hh = 8'h12, cur_mm = 8'h34, cur_ss = 8'h56;
  logic [7:0] al_hh = 8'h07, al_mm = 8'h00;
  logic alarm_en_n = 1'b0;
  logic [7:0] tmr_hh = 8'h00, tmr_mm = 8'h00, tmr_ss = 8'h00;
  logic tmr_run = 1'b0;
  logic buzzer;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam int HALF = 8;

  always #4 clk = ~clk;

  chime_buzzer #(.CLK_HZ(16000), .TONE_HZ(1000)) uut (
    .clk(clk), .rst_n(rst_n), .cur_hh(cur_hh), .cur_mm(cur_mm), .cur_ss(cur_ss),
    .al_hh(al_hh), .al_mm(al_mm), .alarm_en_n(alarm_en_n),
    .tmr_hh(tmr_hh), .tmr_mm(tmr_mm), .tmr_ss(tmr_ss), .tmr_run(tmr_run),
    .buzzer(buzzer)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Cycles between the first two buzzer transitions; 0 if it never toggles.
  task automatic measure(output int half, output logic lvl);
    logic prev;
    int last;
    last = -1;
    half = 0;
    repeat (3) @(negedge clk);
    prev = buzzer;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (buzzer !== prev) begin
        if (last >= 0 && half == 0) half = i - last;
        last = i;
        prev = buzzer;
      end
    end
    lvl = buzzer;
  endtask

  task automatic expect_half(input string tag, input int exp);
    int h;
    logic l;
    measure(h, l);
    check(h == exp, tag, h, exp);
    if (exp == 0) check(l === 1'b1, {tag, " level"}, int'(l), 1);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    cur_hh = h; cur_mm = m; cur_ss = s;
  endtask

  task automatic set_timer(input logic run, input logic [7:0] h, input logic [7:0] m,
                           input logic [7:0] s);
    @(negedge clk);
    tmr_run = run; tmr_hh = h; tmr_mm = m; tmr_ss = s;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(buzzer === 1'b1, "R10 buzzer high in reset", int'(buzzer), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    set_time(8'h12, 8'h34, 8'h56);
    expect_half("R7 idle silent", 0);
  endtask

  task automatic t_chime();
    set_time(8'h09, 8'h59, 8'h52);
    expect_half("R3 R1 chime even sec high tone", HALF);
    set_time(8'h09, 8'h59, 8'h53);
    expect_half("R2 R8 chime odd sec low tone", 2 * HALF);
    set_time(8'h09, 8'h59, 8'h50);
    expect_half("R3 chime first second", HALF);
    set_time(8'h09, 8'h59, 8'h49);
    expect_half("R3 chime before window", 0);
    set_time(8'h09, 8'h58, 8'h55);
    expect_half("R3 chime wrong minute", 0);
  endtask

  task automatic t_alarm();
    @(negedge clk); al_hh = 8'h07; al_mm = 8'h30; alarm_en_n = 1'b0;
    set_time(8'h07, 8'h30, 8'h00);
    expect_half("R4 alarm start of minute", HALF);
    set_time(8'h07, 8'h30, 8'h37);
    expect_half("R4 R8 alarm odd sec", 2 * HALF);
    set_time(8'h07, 8'h31, 8'h00);
    expect_half("R4 alarm over next minute", 0);
    set_time(8'h07, 8'h30, 8'h20);
    @(negedge clk); alarm_en_n = 1'b1;
    expect_half("R5 alarm muted", 0);
    set_time(8'h11, 8'h59, 8'h54);
    expect_half("R5 chime ignores mute", HALF);
    @(negedge clk); alarm_en_n = 1'b0;
  endtask

  task automatic t_timer();
    set_time(8'h12, 8'h34, 8'h12);
    set_timer(1'b1, 8'h00, 8'h00, 8'h10);
    expect_half("R6 timer at ten", HALF);
    set_timer(1'b1, 8'h00, 8'h00, 8'h03);
    expect_half("R6 R8 timer uses own seconds", 2 * HALF);
    set_timer(1'b1, 8'h00, 8'h00, 8'h01);
    expect_half("R6 timer last second", 2 * HALF);
    set_timer(1'b1, 8'h00, 8'h00, 8'h11);
    expect_half("R6 timer above window", 0);
    set_timer(1'b1, 8'h00, 8'h00, 8'h00);
    expect_half("R6 timer expired", 0);
    set_timer(1'b1, 8'h00, 8'h01, 8'h05);
    expect_half("R6 timer minutes left", 0);
    set_timer(1'b0, 8'h00, 8'h00, 8'h05);
    expect_half("R6 timer stopped", 0);
  endtask

  task automatic t_priority();
    @(negedge clk); al_hh = 8'h06; al_mm = 8'h15; alarm_en_n = 1'b0;
    set_time(8'h06, 8'h15, 8'h12);
    set_timer(1'b1, 8'h00, 8'h00, 8'h05);
    expect_half("R9 alarm over timer", HALF);
    set_time(8'h06, 8'h59, 8'h51);
    set_timer(1'b1, 8'h00, 8'h00, 8'h04);
    expect_half("R9 chime over timer", 2 * HALF);
    set_timer(1'b0, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_chime();
    t_alarm();
    t_timer();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule